// File: doc/BRIEF.md
# Pipelined Range-Selected Polynomial Evaluator

This block computes a fixed fifth-order style polynomial of a 32-bit unsigned sample. It uses nested multiply-accumulate (Horner) evaluation. One of two coefficient sets is used, chosen by the address-like window that the sample falls in. A sample outside both windows is flagged as a range error, and its result is forced to zero.

The arithmetic chain has five multiplies and five adds. A register follows every multiply and every add, so each clock stage holds exactly one operation. A new sample can enter on every clock. The chain is preceded by one entry stage, which registers the sample together with a 2-bit tag naming its coefficient set. That tag and the sample travel down the pipe with the partial result, so every stage works on the values that belong to its own sample. A valid bit and a range-error bit travel alongside and appear at the output with the result.

Top module: `horner_pipe`

## Requirements
- R1: `out_valid` equals `in_valid` delayed by exactly 11 clock cycles. The entry stage takes one cycle and the ten arithmetic stages take one cycle each.
- R2: For 0x08000000 <= q < 0x0A000000 the result is computed with the low-window set: c4=0x9E2C2258, c3=0x5AF892E0, c2=0x445B7440, c1=0x79481740, c0=0x74599F60, scale=0x058B90C0.
- R3: For 0x0A000000 <= q < 0x0C000000 the result is computed with the high-window set: c4=0xF48F5786, c3=0x75F846E8, c2=0x5D882000, c1=0x21558EC0, c0=0xFB942240, scale=0x258B90C0.
- R4: A sample below 0x08000000 or at or above 0x0C000000 gives `out_result` = 0 and `out_range_err` = 1. An in-window sample gives `out_range_err` = 0.
- R5: The result is ((q·(q·(q·(q·c4+c3)+c2)+c1)+c0)+q)·scale. Every product keeps its low 32 bits and every sum wraps modulo 2^32.
- R6: Samples presented on consecutive cycles are each evaluated with their own q and their own coefficient set, including when the window changes from one sample to the next.
- R7: A synchronous reset clears every valid bit. No sample that was in flight when reset was applied produces an `out_valid`.
- R8: The window edges are inclusive at the lower bound and exclusive at the upper bound: 0x07FFFFFF is out, 0x08000000 and 0x09FFFFFF are low, 0x0A000000 and 0x0BFFFFFF are high, 0x0C000000 is out.
- R9: A cycle with `in_valid` low creates a bubble. No `out_valid` appears for it, and it does not shift the timing of the samples around it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high, clears valid bits |
| in_valid | input | 1 | Sample strobe |
| in_sample | input | 32 | Unsigned input sample q |
| out_valid | output | 1 | Result strobe, 11 cycles after the sample |
| out_result | output | 32 | Polynomial result (zero on range error) |
| out_range_err | output | 1 | The sample was outside both windows |

## Verification
Two situations are provoked in the same cycle.

- **Reset meets a new sample.** Reset is raised in the cycle in which a new sample is strobed in, while five earlier samples are still in flight. This is judged by the absence of any `out_valid` for the following cycles, and by samples sent after the reset coming out with the correct values and timing.
- **A window change meets neighbouring samples.** Out-of-window, low-window and high-window samples are driven on back-to-back cycles. The arithmetic stages then hold neighbours with different sets at the same moment. This is judged by the scoreboard comparing every result, error flag and arrival cycle against an independent model in the bench.

// File: rtl/horner_pipe_pkg.sv
package horner_pipe_pkg;

    localparam int DATA_W     = 32;
    localparam int NUM_STAGES = 10;
    localparam int LATENCY    = NUM_STAGES + 1;

    typedef logic [DATA_W-1:0] word_t;

    typedef enum logic [1:0] {
        SET_NONE = 2'd0,
        SET_LOW  = 2'd1,
        SET_HIGH = 2'd2
    } coef_set_e;

    // Coefficient slot indices
    localparam logic [2:0] IDX_C0    = 3'd0;
    localparam logic [2:0] IDX_C1    = 3'd1;
    localparam logic [2:0] IDX_C2    = 3'd2;
    localparam logic [2:0] IDX_C3    = 3'd3;
    localparam logic [2:0] IDX_C4    = 3'd4;
    localparam logic [2:0] IDX_SCALE = 3'd5;

    // One pipeline lane: sample, its set tag, flags and the partial result
    typedef struct packed {
        logic      valid;
        logic      range_err;
        coef_set_e set;
        word_t     q;
        word_t     acc;
    } lane_t;

    // Static description of what one arithmetic stage does
    typedef struct packed {
        logic       is_mul;
        logic       a_from_q;
        logic       b_from_coef;
        logic [2:0] coef_idx;
    } stage_op_t;

    function automatic word_t coef_value(coef_set_e s, logic [2:0] idx);
        word_t v;
        v = '0;
        unique case (s)
            SET_LOW: begin
                case (idx)
                    IDX_C4:    v = 32'h9E2C_2258;
                    IDX_C3:    v = 32'h5AF8_92E0;
                    IDX_C2:    v = 32'h445B_7440;
                    IDX_C1:    v = 32'h7948_1740;
                    IDX_C0:    v = 32'h7459_9F60;
                    IDX_SCALE: v = 32'h058B_90C0;
                    default:   v = '0;
                endcase
            end
            SET_HIGH: begin
                case (idx)
                    IDX_C4:    v = 32'hF48F_5786;
                    IDX_C3:    v = 32'h75F8_46E8;
                    IDX_C2:    v = 32'h5D88_2000;
                    IDX_C1:    v = 32'h2155_8EC0;
                    IDX_C0:    v = 32'hFB94_2240;
                    IDX_SCALE: v = 32'h258B_90C0;
                    default:   v = '0;
                endcase
            end
            default: v = '0;   // no set: zero scale forces a zero result
        endcase
        return v;
    endfunction

    // Stage n (1..NUM_STAGES) of the nested evaluation
    function automatic stage_op_t stage_op(int unsigned n);
        stage_op_t op;
        op = '{is_mul: 1'b0, a_from_q: 1'b0, b_from_coef: 1'b0, coef_idx: IDX_C0};
        case (n)
            1:  op = '{1'b1, 1'b1, 1'b1, IDX_C4};    // q * c4
            2:  op = '{1'b0, 1'b0, 1'b1, IDX_C3};    // + c3
            3:  op = '{1'b1, 1'b0, 1'b0, IDX_C0};    // * q
            4:  op = '{1'b0, 1'b0, 1'b1, IDX_C2};    // + c2
            5:  op = '{1'b1, 1'b0, 1'b0, IDX_C0};    // * q
            6:  op = '{1'b0, 1'b0, 1'b1, IDX_C1};    // + c1
            7:  op = '{1'b1, 1'b0, 1'b0, IDX_C0};    // * q
            8:  op = '{1'b0, 1'b0, 1'b1, IDX_C0};    // + c0
            9:  op = '{1'b0, 1'b0, 1'b0, IDX_C0};    // + q
            10: op = '{1'b1, 1'b0, 1'b1, IDX_SCALE}; // * scale
            default: op = '{1'b0, 1'b0, 1'b0, IDX_C0};
        endcase
        return op;
    endfunction

endpackage

// File: rtl/horner_range_sel.sv
module horner_range_sel
    import horner_pipe_pkg::*;
#(
    parameter word_t LOW_BASE = 32'h0800_0000,
    parameter word_t MID_BASE = 32'h0A00_0000,
    parameter word_t TOP_BASE = 32'h0C00_0000
) (
    input  word_t     sample,
    output coef_set_e set_o,
    output logic      range_err_o
);

    always_comb begin
        if (sample >= LOW_BASE && sample < MID_BASE) begin
            set_o = SET_LOW;
        end else if (sample >= MID_BASE && sample < TOP_BASE) begin
            set_o = SET_HIGH;
        end else begin
            set_o = SET_NONE;
        end
        range_err_o = (set_o == SET_NONE);
    end

endmodule

// File: rtl/horner_op_stage.sv
module horner_op_stage
    import horner_pipe_pkg::*;
#(
    parameter int unsigned STAGE_NUM = 1
) (
    input  logic  clk,
    input  logic  rst,
    input  lane_t lane_i,
    output lane_t lane_o
);

    localparam stage_op_t OP = stage_op(STAGE_NUM);

    lane_t lane_d, lane_q;
    word_t coef, opa, opb;

    always_comb begin
        coef       = coef_value(lane_i.set, OP.coef_idx);
        opa        = OP.a_from_q    ? lane_i.q : lane_i.acc;
        opb        = OP.b_from_coef ? coef     : lane_i.q;
        lane_d     = lane_i;
        // both results are truncated to the word width (mod 2^DATA_W)
        lane_d.acc = OP.is_mul ? word_t'(opa * opb) : word_t'(opa + opb);
    end

    always_ff @(posedge clk) begin
        lane_q <= lane_d;
        if (rst) begin
            lane_q.valid <= 1'b0;
        end
    end

    assign lane_o = lane_q;

    AST_STAGE_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !lane_q.valid); // R7

    AST_STAGE_TAG_TRAVELS: assert property (@(posedge clk) disable iff (rst)
        lane_i.valid |=> (lane_q.valid && lane_q.q == $past(lane_i.q)
                          && lane_q.range_err == $past(lane_i.range_err))); // R6

endmodule

// File: rtl/horner_pipe.sv
module horner_pipe
    import horner_pipe_pkg::*;
#(
    parameter word_t LOW_BASE = 32'h0800_0000,
    parameter word_t MID_BASE = 32'h0A00_0000,
    parameter word_t TOP_BASE = 32'h0C00_0000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_sample,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_result,
    output logic              out_range_err
);

    localparam int CNT_W = $clog2(LATENCY + 2) + 1;

    coef_set_e sel_set;
    logic      sel_err;

    horner_range_sel #(
        .LOW_BASE (LOW_BASE),
        .MID_BASE (MID_BASE),
        .TOP_BASE (TOP_BASE)
    ) u_sel (
        .sample      (in_sample),
        .set_o       (sel_set),
        .range_err_o (sel_err)
    );

    // Entry stage: register the sample with its set tag
    lane_t entry_d, entry_q;

    always_comb begin
        entry_d.valid     = in_valid;
        entry_d.range_err = sel_err;
        entry_d.set       = sel_set;
        entry_d.q         = in_sample;
        entry_d.acc       = '0;
    end

    always_ff @(posedge clk) begin
        entry_q <= entry_d;
        if (rst) begin
            entry_q.valid <= 1'b0;
        end
    end

    lane_t lanes [NUM_STAGES+1];
    assign lanes[0] = entry_q;

    for (genvar g = 0; g < NUM_STAGES; g++) begin : g_stage
        horner_op_stage #(
            .STAGE_NUM (g + 1)
        ) u_stage (
            .clk    (clk),
            .rst    (rst),
            .lane_i (lanes[g]),
            .lane_o (lanes[g+1])
        );
    end

    assign out_valid     = lanes[NUM_STAGES].valid;
    assign out_result    = lanes[NUM_STAGES].acc;
    assign out_range_err = lanes[NUM_STAGES].range_err;

    // Cycles since reset, used to keep the latency check inside the post-reset window
    logic [CNT_W-1:0] since_rst_d, since_rst_q;

    always_comb begin
        since_rst_d = since_rst_q;
        if (since_rst_q <= CNT_W'(LATENCY)) begin
            since_rst_d = since_rst_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            since_rst_q <= '0;
        end else begin
            since_rst_q <= since_rst_d;
        end
    end

    AST_OUT_LATENCY: assert property (@(posedge clk) disable iff (rst)
        (since_rst_q > CNT_W'(LATENCY)) |-> (out_valid == $past(in_valid, LATENCY))); // R1

    AST_ZERO_ON_RANGE_ERR: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_range_err) |-> (out_result == '0)); // R4

endmodule

// File: tb/horner_pipe_tb.sv
module horner_pipe_tb;

    localparam int LAT = 11;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] in_sample = '0;
    logic        out_valid;
    logic [31:0] out_result;
    logic        out_range_err;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [31:0] res;
        logic        err;
        int          due;
        string       tag;
    } exp_t;

    exp_t sb[$];

    always #2 clk = ~clk;   // 250 MHz
    always @(posedge clk) cyc <= cyc + 1;

    horner_pipe u_dut (
        .clk           (clk),
        .rst           (rst),
        .in_valid      (in_valid),
        .in_sample     (in_sample),
        .out_valid     (out_valid),
        .out_result    (out_result),
        .out_range_err (out_range_err)
    );

    // Independent reference: {error, result}
    function automatic logic [32:0] model(logic [31:0] q);
        logic [31:0] k4, k3, k2, k1, k0, ks, y;
        if (q >= 32'h0800_0000 && q < 32'h0A00_0000) begin
            k4 = 32'h9E2C2258; k3 = 32'h5AF892E0; k2 = 32'h445B7440;
            k1 = 32'h79481740; k0 = 32'h74599F60; ks = 32'h058B90C0;
        end else if (q >= 32'h0A00_0000 && q < 32'h0C00_0000) begin
            k4 = 32'hF48F5786; k3 = 32'h75F846E8; k2 = 32'h5D882000;
            k1 = 32'h21558EC0; k0 = 32'hFB942240; ks = 32'h258B90C0;
        end else begin
            return {1'b1, 32'h0};
        end
        y = q * k4 + k3;
        y = q * y + k2;
        y = q * y + k1;
        y = q * y + k0;
        y = (y + q) * ks;
        return {1'b0, y};
    endfunction

    task automatic send(input logic [31:0] q, input string tag);
        exp_t e;
        logic [32:0] m;
        @(negedge clk);
        in_valid  = 1'b1;
        in_sample = q;
        m     = model(q);
        e.res = m[31:0];
        e.err = m[32];
        e.due = cyc + LAT;
        e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    // Monitor: pop and compare away from the active edge
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            checks++;
            if (sb.size() == 0) begin
                errors++;
                $display("FAIL R7/R9: unexpected out_valid at cycle %0d (actual valid=1, expected 0)", cyc);
            end else begin
                exp_t e;
                e = sb.pop_front();
                if (out_result !== e.res || out_range_err !== e.err || cyc != e.due) begin
                    errors++;
                    $display("FAIL %s: result=%h err=%b cycle=%0d, expected result=%h err=%b cycle=%0d",
                             e.tag, out_result, out_range_err, cyc, e.res, e.err, e.due);
                end
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R7: reset state
        checks++;
        if (out_valid !== 1'b0) begin
            errors++;
            $display("FAIL R7: out_valid after reset actual=%b expected 0", out_valid);
        end

        // R8: window edges, each sample alone
        send(32'h07FF_FFFF, "R8"); idle(2);
        send(32'h0800_0000, "R8"); idle(1);
        send(32'h09FF_FFFF, "R8");
        send(32'h0A00_0000, "R8");
        send(32'h0BFF_FFFF, "R8"); idle(3);
        send(32'h0C00_0000, "R8");

        // R4: far out-of-window values
        send(32'h0000_0000, "R4");
        send(32'hFFFF_FFFF, "R4");

        // R2, R3, R5: typical in-window values, products overflow
        send(32'h0812_3457, "R2");
        send(32'h0988_7766, "R2");
        send(32'h0A5A_5A5A, "R3");
        send(32'h0B00_0001, "R5");

        // R6: back-to-back burst alternating windows
        for (int i = 0; i < 24; i++) begin
            logic [31:0] v;
            v = 32'h0700_0000 + 32'(i) * 32'h0023_4567;
            send(v, "R6");
        end

        // R9: sparse samples with bubbles
        for (int i = 0; i < 6; i++) begin
            send(32'h0A10_0000 + 32'(i) * 32'h0031_0003, "R9");
            idle(i % 3 + 1);
        end
        idle(LAT + 4);

        // R9: pipe drained, no stray valids
        begin
            int seen;
            seen = 0;
            for (int i = 0; i < 20; i++) begin
                @(negedge clk);
                if (out_valid) seen++;
            end
            checks++;
            if (seen != 0 || sb.size() != 0) begin
                errors++;
                $display("FAIL R9: stray valids=%0d pending=%0d, expected 0 and 0", seen, sb.size());
            end
        end

        // R7: reset while samples in flight, coinciding with a new strobe
        send(32'h0811_1111, "R7");
        send(32'h0A22_2222, "R7");
        send(32'h0933_3333, "R7");
        send(32'h0B44_4444, "R7");
        send(32'h0855_5555, "R7");
        @(negedge clk);
        rst       = 1'b1;
        in_valid  = 1'b1;
        in_sample = 32'h0866_6666;
        sb.delete();
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        begin
            int seen;
            seen = 0;
            for (int i = 0; i < LAT + 6; i++) begin
                @(negedge clk);
                if (out_valid) seen++;
            end
            checks++;
            if (seen != 0) begin
                errors++;
                $display("FAIL R7: valids after reset actual=%0d expected 0", seen);
            end
        end

        // R2/R3 after reset: pipe works again
        send(32'h0877_7777, "R2");
        send(32'h0B88_8888, "R3");
        idle(LAT + 4);

        checks++;
        if (sb.size() != 0) begin
            errors++;
            $display("FAIL R1: results missing actual=%0d expected 0", sb.size());
        end

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule